// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block produces the fetch address for a small microcontroller with 13-bit instruction words. Each cycle it looks at the instruction currently held at the fetch address, decides the next address, and updates the program counter on the clock edge. It handles absolute jumps and subroutine calls whose targets join page-select bits with a 10-bit literal. It also handles a return that hands an 8-bit literal to the accumulator, a software interrupt that vectors to a fixed address, and a page-select write. A small circular return stack holds the saved addresses.

The execute unit may ask for the following instruction to be skipped. The sequencer then fetches that instruction but marks it as killed: it has no effect on the stack, the page bits or the accumulator, and the counter simply moves on. In effect the counter has advanced by two. Instruction memory, hardware interrupts and all data-path work other than the accumulator load on return belong to other blocks.

Top module: `pc_sequencer`

## Requirements
- R1: While reset (rst_n low) is held and in the first cycle after it, pc_o is 0, page_o is 0, kill_o is 0 and the return stack pointer is at its empty position.
- R2: An instruction that is not a transfer or page write (for example 13'h0000) advances pc_o by one on the next edge, wrapping from all-ones to 0.
- R3: A jump (instr_i[12:10] = 3'b101) loads pc_o with {page_o[PAGE_W-1:0], instr_i[9:0]} and leaves the stack unchanged.
- R4: A call (instr_i[12:10] = 3'b100) pushes pc_o+1 onto the return stack and loads pc_o with {page_o[PAGE_W-1:0], instr_i[9:0]}.
- R5: A return-with-literal (instr_i[12:8] = 5'b11100) pops the stack into pc_o, and during that same cycle drives acc_we_o high with acc_data_o = instr_i[7:0]. acc_we_o is low in every other cycle.
- R6: The software interrupt (instr_i = 13'h1E02) pushes pc_o+1 and loads pc_o with INT_VEC (default 1).
- R7: A page write (instr_i[12:4] = 9'b1_1110_1000) stores instr_i[3:0] into page_o, advances pc_o by one, and steers later jumps and calls.
- R8: skip_req_i high during a live, non-transfer instruction kills the next instruction. That instruction has kill_o high, and it changes no stack, page or accumulator state. pc_o still advances by one.
- R9: skip_req_i is ignored during a killed instruction and during a call, jump, return or interrupt. The instruction after those executes normally.
- R10: The return stack holds STACK_DEPTH (default 8) entries and wraps circularly. A push beyond the depth overwrites the oldest entry. A pop past empty reads the slot the pointer wraps to. No error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 13 | Instruction held at the current fetch address |
| skip_req_i | input | 1 | Execute unit asks to skip the next instruction |
| pc_o | output | PC_W | Current fetch address |
| page_o | output | 4 | Page-select register |
| kill_o | output | 1 | Current instruction is skipped and must act as a no-op |
| acc_we_o | output | 1 | Accumulator write strobe for return-with-literal |
| acc_data_o | output | 8 | Literal to load into the accumulator |

## Verification
The embedded properties watch a number of things on every cycle. They check the reset value of the counter and the page bits. They check that a live jump or interrupt lands on its target or vector, and that a killed instruction only advances the counter and leaves the page bits alone. Two kills never come in a row, a return lands on the popped address, and push and pop never happen together. The stack pointer also moves by exactly one slot with wrap. Some behaviours need the bench's directed sequences: the exact addresses saved by calls and interrupts, the accumulator literal, page bits steering later jumps, and the last-in-first-out order across an overflow and a wrapped pop. The bench also confirms that a skip request during a transfer does not carry over.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   localparam int INSTR_W    = 13;
   localparam int LIT_W      = 10;
   localparam int PAGE_REG_W = 4;
   localparam int ACC_W      = 8;

   typedef enum logic [2:0] {
      OP_SEQ  = 3'd0,
      OP_CALL = 3'd1,
      OP_JMP  = 3'd2,
      OP_RETL = 3'd3,
      OP_INT  = 3'd4,
      OP_PAGE = 3'd5
   } seq_op_e;

   function automatic logic is_transfer(seq_op_e op);
      return (op == OP_CALL) || (op == OP_JMP) || (op == OP_RETL) || (op == OP_INT);
   endfunction
endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
   import pcseq_pkg::*;
(
   input  logic [INSTR_W-1:0]    instr,
   output seq_op_e               op,
   output logic [LIT_W-1:0]      lit_addr,
   output logic [ACC_W-1:0]      lit_acc,
   output logic [PAGE_REG_W-1:0] lit_page
);
   always_comb begin
      op = OP_SEQ;
      if (instr[12:10] == 3'b100)             op = OP_CALL;
      else if (instr[12:10] == 3'b101)        op = OP_JMP;
      else if (instr[12:8] == 5'b11100)       op = OP_RETL;
      else if (instr == 13'h1E02)             op = OP_INT;
      else if (instr[12:4] == 9'b1_1110_1000) op = OP_PAGE;
   end

   assign lit_addr = instr[LIT_W-1:0];
   assign lit_acc  = instr[ACC_W-1:0];
   assign lit_page = instr[PAGE_REG_W-1:0];
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] top
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((1 << PTR_W) == DEPTH);

   logic [DATA_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  sp_q, sp_inc, sp_dec;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pcseq_stack: DEPTH must be at least 2");
      end
      if (POW2) begin : g_wrap_natural
         assign sp_inc = sp_q + PTR_W'(1);
         assign sp_dec = sp_q - PTR_W'(1);
      end else begin : g_wrap_compare
         assign sp_inc = (sp_q == PTR_W'(DEPTH - 1)) ? '0 : sp_q + PTR_W'(1);
         assign sp_dec = (sp_q == '0) ? PTR_W'(DEPTH - 1) : sp_q - PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    sp_q <= '0;
      else if (push) sp_q <= sp_inc;
      else if (pop)  sp_q <= sp_dec;
   end

   always_ff @(posedge clk) begin
      if (push) slots[sp_q] <= push_data;
   end

   assign top = slots[sp_dec];

   assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   assert_ptr_up_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (sp_q == ((32'($past(sp_q)) + 1) % DEPTH)));

   assert_ptr_down_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (sp_q == ((32'($past(sp_q)) + DEPTH - 1) % DEPTH)));

   assert_ptr_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (sp_q == '0));
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
   import pcseq_pkg::*;
#(
   parameter int PC_W    = 12,
   parameter int PAGE_W  = 2,
   parameter int INT_VEC = 1
) (
   input  seq_op_e               op,
   input  logic                  kill,
   input  logic [PC_W-1:0]       pc,
   input  logic [PAGE_REG_W-1:0] page,
   input  logic [LIT_W-1:0]      lit_addr,
   input  logic [PC_W-1:0]       stack_top,
   output logic [PC_W-1:0]       pc_next,
   output logic [PC_W-1:0]       pc_inc,
   output logic                  push,
   output logic                  pop,
   output logic                  page_we
);
   logic [PC_W-1:0] far_target;

   assign pc_inc     = pc + PC_W'(1);
   assign far_target = {page[PAGE_W-1:0], lit_addr};

   always_comb begin
      pc_next = pc_inc;
      if (!kill) begin
         unique case (op)
            OP_CALL, OP_JMP: pc_next = far_target;
            OP_RETL:         pc_next = stack_top;
            OP_INT:          pc_next = PC_W'(INT_VEC);
            default:         pc_next = pc_inc;
         endcase
      end
   end

   assign push    = !kill && ((op == OP_CALL) || (op == OP_INT));
   assign pop     = !kill && (op == OP_RETL);
   assign page_we = !kill && (op == OP_PAGE);
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int PAGE_W      = 2,
   parameter int STACK_DEPTH = 8,
   parameter int INT_VEC     = 1,
   localparam int PC_W       = LIT_W + PAGE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [INSTR_W-1:0]    instr_i,
   input  logic                  skip_req_i,
   output logic [PC_W-1:0]       pc_o,
   output logic [PAGE_REG_W-1:0] page_o,
   output logic                  kill_o,
   output logic                  acc_we_o,
   output logic [ACC_W-1:0]      acc_data_o
);
   generate
      if (PAGE_W < 1 || PAGE_W > PAGE_REG_W) begin : g_bad_page
         $error("pc_sequencer: PAGE_W must lie in 1..4");
      end
      if (INT_VEC < 0 || INT_VEC >= (1 << PC_W)) begin : g_bad_vec
         $error("pc_sequencer: INT_VEC outside address space");
      end
   endgenerate

   seq_op_e                op;
   logic [LIT_W-1:0]       lit_addr;
   logic [ACC_W-1:0]       lit_acc;
   logic [PAGE_REG_W-1:0]  lit_page;
   logic [PC_W-1:0]        pc_q, pc_next, pc_inc, stack_top;
   logic [PAGE_REG_W-1:0]  page_q;
   logic                   kill_q, push, pop, page_we;

   pcseq_decode u_decode (
      .instr    (instr_i),
      .op       (op),
      .lit_addr (lit_addr),
      .lit_acc  (lit_acc),
      .lit_page (lit_page)
   );

   pcseq_next #(.PC_W(PC_W), .PAGE_W(PAGE_W), .INT_VEC(INT_VEC)) u_next (
      .op        (op),
      .kill      (kill_q),
      .pc        (pc_q),
      .page      (page_q),
      .lit_addr  (lit_addr),
      .stack_top (stack_top),
      .pc_next   (pc_next),
      .pc_inc    (pc_inc),
      .push      (push),
      .pop       (pop),
      .page_we   (page_we)
   );

   pcseq_stack #(.DEPTH(STACK_DEPTH), .DATA_W(PC_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (pc_inc),
      .top       (stack_top)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= '0;
         page_q <= '0;
         kill_q <= 1'b0;
      end else begin
         pc_q   <= pc_next;
         if (page_we) page_q <= lit_page;
         kill_q <= skip_req_i && !kill_q && !is_transfer(op);
      end
   end

   assign pc_o       = pc_q;
   assign page_o     = page_q;
   assign kill_o     = kill_q;
   assign acc_we_o   = pop;
   assign acc_data_o = lit_acc;

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pc_o == '0 && page_o == '0 && !kill_o));

   assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_JMP && !kill_o) |=>
         (pc_o == {$past(page_o[PAGE_W-1:0]), $past(instr_i[LIT_W-1:0])}));

   assert_return_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we_o |=> (pc_o == $past(stack_top)));

   assert_int_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INT && !kill_o) |=> (pc_o == PC_W'(INT_VEC)));

   assert_kill_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |=> (pc_o == $past(pc_o) + PC_W'(1) && $stable(page_o)));

   assert_kill_no_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |-> !acc_we_o);

   assert_no_double_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |=> !kill_o);
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] instr = '0;
   logic        skip = 1'b0;
   logic [11:0] pc;
   logic [3:0]  page;
   logic        kill, acc_we;
   logic [7:0]  acc_data;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   pc_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .skip_req_i(skip),
      .pc_o(pc), .page_o(page), .kill_o(kill),
      .acc_we_o(acc_we), .acc_data_o(acc_data)
   );

   localparam logic [12:0] NOP = 13'h0000;
   function automatic logic [12:0] op_jmp(input logic [9:0] k);  return 13'h1400 | 13'(k); endfunction
   function automatic logic [12:0] op_call(input logic [9:0] k); return 13'h1000 | 13'(k); endfunction
   function automatic logic [12:0] op_retl(input logic [7:0] k); return 13'h1C00 | 13'(k); endfunction
   function automatic logic [12:0] op_page(input logic [3:0] k); return 13'h1E80 | 13'(k); endfunction
   localparam logic [12:0] OP_INT = 13'h1E02;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic seen_we;
   logic [7:0] seen_data;
   logic seen_kill;

   // drive at negedge, capture combinational outputs, advance one edge
   task automatic step(input logic [12:0] ins, input logic sk);
      instr = ins;
      skip  = sk;
      #1;
      seen_we   = acc_we;
      seen_data = acc_data;
      seen_kill = kill;
      @(posedge clk);
      @(negedge clk);
      skip = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 pc", 32'(pc), 32'h0);
      chk("R1 page", 32'(page), 32'h0);
      chk("R1 kill", 32'(kill), 32'h0);
   endtask

   task automatic t_seq;
      step(NOP, 0); step(NOP, 0); step(NOP, 0);
      chk("R2 sequential", 32'(pc), 32'h3);
      chk("R5 no acc write on plain op", 32'(seen_we), 32'h0);
   endtask

   task automatic t_page_jmp;
      step(op_page(4'h3), 0);
      chk("R7 page value", 32'(page), 32'h3);
      chk("R7 pc advance", 32'(pc), 32'h4);
      step(op_jmp(10'h155), 0);
      chk("R3 jump target", 32'(pc), 32'hD55);
   endtask

   task automatic t_call_ret;
      step(op_call(10'h010), 0);
      chk("R4 call target", 32'(pc), 32'hC10);
      step(NOP, 0);
      step(op_retl(8'h5A), 0);
      chk("R5 acc strobe", 32'(seen_we), 32'h1);
      chk("R5 acc literal", 32'(seen_data), 32'h5A);
      chk("R4 return address", 32'(pc), 32'hD56);
   endtask

   task automatic t_int;
      step(OP_INT, 0);
      chk("R6 vector", 32'(pc), 32'h001);
      step(op_retl(8'h00), 0);
      chk("R6 saved address", 32'(pc), 32'hD57);
   endtask

   task automatic t_skip;
      step(NOP, 1);
      chk("R8 skip source advance", 32'(pc), 32'hD58);
      step(op_jmp(10'h000), 1);
      chk("R8 kill flagged", 32'(seen_kill), 32'h1);
      chk("R8 killed jump inert", 32'(pc), 32'hD59);
      step(op_jmp(10'h000), 0);
      chk("R9 skip during kill ignored", 32'(seen_kill), 32'h0);
      chk("R9 jump after kill", 32'(pc), 32'hC00);
      step(NOP, 1);
      step(op_retl(8'h77), 0);
      chk("R8 killed return no acc", 32'(seen_we), 32'h0);
      chk("R8 killed return pc", 32'(pc), 32'hC02);
      step(NOP, 1);
      step(op_page(4'h1), 0);
      chk("R8 killed page write", 32'(page), 32'h3);
      chk("R8 killed page pc", 32'(pc), 32'hC04);
      step(op_call(10'h020), 1);
      chk("R9 call with skip", 32'(pc), 32'hC20);
      step(op_jmp(10'h030), 0);
      chk("R9 no kill after call", 32'(seen_kill), 32'h0);
      chk("R9 jump after call", 32'(pc), 32'hC30);
      step(op_retl(8'h01), 0);
      chk("R4 call pushed address", 32'(pc), 32'hC05);
   endtask

   task automatic t_wrap;
      step(op_jmp(10'h3FF), 0);
      chk("R3 top of space", 32'(pc), 32'hFFF);
      step(NOP, 0);
      chk("R2 pc wrap", 32'(pc), 32'h000);
   endtask

   task automatic t_overflow;
      step(op_page(4'h0), 0);
      step(op_jmp(10'h100), 0);
      chk("R3 page zero jump", 32'(pc), 32'h100);
      for (int i = 1; i <= 9; i++) step(op_call(10'(32'h100 + i)), 0);
      chk("R10 deep call target", 32'(pc), 32'h109);
      for (int i = 0; i < 8; i++) begin
         step(op_retl(8'h00), 0);
         chk("R10 lifo order", 32'(pc), 32'h109 - 32'(i));
      end
      step(op_retl(8'h00), 0);
      chk("R10 wrapped pop", 32'(pc), 32'h109);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_seq;
      t_page_jmp;
      t_call_ret;
      t_int;
      t_skip;
      t_wrap;
      t_overflow;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule